// File: doc/BRIEF.md
# Packed 4:2:2 Luma/Chroma to RGB Pixel Converter

The block takes a stream of 32-bit words. Each word holds two luma samples and one shared pair of chroma samples. For each word it produces two 32-bit RGB pixels, one per cycle, on a valid/ready output stream.

Each channel is computed the same way. The block removes the video offsets from the samples, then forms a weighted sum with fixed-point coefficients scaled by 2^16. It shifts the sum right arithmetically by 16 bits and saturates the result to an 8-bit range. A full 640x480 picture therefore needs 320x480 input words.

The input side accepts a new word only when the pixel pair currently held can be drained. Under continuous flow the block sustains one output pixel per cycle.

Top module: `yuv422_rgb_unpack`

## Requirements
- R1: Input byte lanes are: bits 7:0 first luma, 15:8 V chroma, 23:16 second luma, 31:24 U chroma. The pixel built from the first luma leaves before the pixel built from the second luma, and both pixels use the same U and V.
- R2: Before weighting, 16 is subtracted from luma and 128 from each chroma sample. Luma 16 with both chroma at 128 gives the pixel 0x00000000.
- R3: Red equals (76283*Y' + 104595*V') shifted right arithmetically by 16.
- R4: Green equals (76283*Y' - 53281*V' - 25624*U') shifted right arithmetically by 16.
- R5: Blue equals (76283*Y' + 132252*U') shifted right arithmetically by 16.
- R6: A channel whose shifted sum is negative outputs 0.
- R7: A channel whose shifted sum exceeds 255 outputs 255.
- R8: The output pixel holds red in bits 7:0, green in 15:8 and blue in 23:16. Bits 31:24 are 0.
- R9: After reset, output valid is low and input ready is high. Input ready is low while the first pixel of a pair is pending. It is also low while the second pixel is pending and output ready is low.
- R10: While output valid is high and output ready is low, output valid stays high and the pixel value is unchanged on the next cycle.
- R11: With output ready held high and input always valid, a new word is accepted in the same cycle that the previous pair's second pixel is accepted. N words take 2N+1 cycles from the first acceptance to the last pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Block can take the input word |
| inData | input | 32 | Packed word: first luma, V, second luma, U (low byte first) |
| outValid | output | 1 | Output pixel available |
| outReady | input | 1 | Consumer takes the pixel |
| outPixel | output | 32 | RGB pixel: red low byte, then green, then blue, top byte zero |

## Verification
Several properties are checked on every cycle. Held pixels stay unchanged under backpressure. The second pixel of a pair always follows the first. Input ready stays low while a pair is being drained. The captured word always matches the accepted input.

The arithmetic needs the bench's scenarios to show it. These cover the coefficient weighting, the offset removal, saturation at both ends, the byte lane positions and the sustained one-pixel-per-cycle rate. The bench compares the outputs against a reference model computed from the requirements, using neutral, saturating and mixed sample values.

// File: rtl/yuv422_rgb_pkg.sv
package yuv422_rgb_pkg;
  localparam int WORD_W    = 32;
  localparam int CHAN_W    = 8;
  localparam int FRAC_BITS = 16;
  localparam int COEF_Y    = 76283;
  localparam int COEF_RV   = 104595;
  localparam int COEF_GV   = 53281;
  localparam int COEF_GU   = 25624;
  localparam int COEF_BU   = 132252;
  localparam int LUMA_OFS  = 16;
  localparam int CHROMA_OFS = 128;

  typedef struct packed {
    logic load;       // capture a new input word
    logic selSecond;  // present the pixel built from the second luma
  } pairStrobes_t;
endpackage

// File: rtl/yuv422_rgb_ctrl.sv
module yuv422_rgb_ctrl
  import yuv422_rgb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output pairStrobes_t strobes
);
  typedef enum logic [1:0] {ST_EMPTY, ST_FIRST, ST_SECOND} pairState_t;
  pairState_t state, stateNext;

  logic inFire, outFire;

  always_comb begin
    inReady  = (state == ST_EMPTY) || (state == ST_SECOND && outReady);
    outValid = (state != ST_EMPTY);
    inFire   = inValid && inReady;
    outFire  = outValid && outReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_EMPTY:  if (inFire) stateNext = ST_FIRST;
      ST_FIRST:  if (outFire) stateNext = ST_SECOND;
      ST_SECOND: if (outFire) stateNext = inFire ? ST_FIRST : ST_EMPTY;
      default:   stateNext = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_EMPTY;
    else        state <= stateNext;
  end

  always_comb begin
    strobes.load      = inFire;
    strobes.selSecond = (state == ST_SECOND);
  end

  // R1: first pixel accepted -> second pixel of the same pair presented next
  assert_pair_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !strobes.selSecond) |=> (outValid && strobes.selSecond));

  // R9: no new word while a pair is still being drained
  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !(strobes.selSecond && outReady)) |-> !inReady);

  // R11: refill in the same cycle the second pixel leaves
  assert_refill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && strobes.selSecond && outReady && inValid) |=> (outValid && !strobes.selSecond));
endmodule

// File: rtl/yuv422_rgb_datapath.sv
module yuv422_rgb_datapath
  import yuv422_rgb_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pairStrobes_t        strobes,
  input  logic [WORD_W-1:0]   inData,
  output logic [WORD_W-1:0]   outPixel
);
  localparam int PAIR = 2;
  localparam int PAD_W = WORD_W - 3*CHAN_W;
  localparam logic signed [ACC_W-1:0] kY   = COEF_Y;
  localparam logic signed [ACC_W-1:0] kRv  = COEF_RV;
  localparam logic signed [ACC_W-1:0] kGv  = COEF_GV;
  localparam logic signed [ACC_W-1:0] kGu  = COEF_GU;
  localparam logic signed [ACC_W-1:0] kBu  = COEF_BU;
  localparam logic signed [ACC_W-1:0] kLumaOfs = LUMA_OFS;
  localparam logic signed [ACC_W-1:0] kChromaOfs = CHROMA_OFS;
  localparam logic signed [ACC_W-1:0] kMax = (1 << CHAN_W) - 1;

  logic [WORD_W-1:0] heldWord;

  always_ff @(posedge clk) begin
    if (!rst_n)            heldWord <= '0;
    else if (strobes.load) heldWord <= inData;
  end

  function automatic logic signed [ACC_W-1:0] widen(input logic [CHAN_W-1:0] b);
    return $signed({{(ACC_W-CHAN_W){1'b0}}, b});
  endfunction

  function automatic logic [CHAN_W-1:0] clampChan(input logic signed [ACC_W-1:0] s);
    if (s < 0)         return '0;
    else if (s > kMax) return '1;
    else               return s[CHAN_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] vOff, uOff;
  always_comb begin
    vOff = widen(heldWord[2*CHAN_W-1:CHAN_W]) - kChromaOfs;
    uOff = widen(heldWord[4*CHAN_W-1:3*CHAN_W]) - kChromaOfs;
  end

  logic [WORD_W-1:0] lanePixel [PAIR];

  for (genvar lane = 0; lane < PAIR; lane++) begin : g_lane
    logic [CHAN_W-1:0]       luma;
    logic signed [ACC_W-1:0] yOff, accR, accG, accB;
    always_comb begin
      luma = heldWord[2*lane*CHAN_W +: CHAN_W];
      yOff = widen(luma) - kLumaOfs;
      accR = (kY * yOff + kRv * vOff) >>> FRAC_BITS;
      accG = (kY * yOff - kGv * vOff - kGu * uOff) >>> FRAC_BITS;
      accB = (kY * yOff + kBu * uOff) >>> FRAC_BITS;
      lanePixel[lane] = {{PAD_W{1'b0}}, clampChan(accB), clampChan(accG), clampChan(accR)};
    end
  end

  assign outPixel = strobes.selSecond ? lanePixel[1] : lanePixel[0];

  // R1: the word used for both pixels is the one accepted
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (heldWord == $past(inData)));
endmodule

// File: rtl/yuv422_rgb_unpack.sv
module yuv422_rgb_unpack
  import yuv422_rgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outPixel
);
  pairStrobes_t strobes;

  yuv422_rgb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobes(strobes)
  );

  yuv422_rgb_datapath #(.ACC_W(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .inData(inData), .outPixel(outPixel)
  );

  // R10: a stalled pixel stays valid and unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outPixel)));

  // R9: output becomes valid only after a word was accepted
  assert_valid_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(inValid && inReady));
endmodule

// File: tb/yuv422_rgb_unpack_bench.sv
module yuv422_rgb_unpack_bench;
  logic clk = 0, rst_n = 0, inValid = 0, outReady = 0;
  logic [31:0] inData = '0;
  logic inReady, outValid;
  logic [31:0] outPixel;
  int total = 0, errors = 0;

  always #5ns clk = ~clk;

  yuv422_rgb_unpack u_yuv422_rgb_unpack (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  function automatic int sat(input int s);
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  // reference from R2..R8
  function automatic logic [31:0] refPix(input logic [31:0] w, input bit second);
    int y, v, u, r, g, b;
    y = (second ? int'(w[23:16]) : int'(w[7:0])) - 16;
    v = int'(w[15:8]) - 128;
    u = int'(w[31:24]) - 128;
    r = sat((76283*y + 104595*v) >>> 16);
    g = sat((76283*y - 53281*v - 25624*u) >>> 16);
    b = sat((76283*y + 132252*u) >>> 16);
    return {8'h00, b[7:0], g[7:0], r[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    inValid = 1; inData = w;
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 0;
  endtask

  task automatic popPixel(output logic [31:0] p);
    @(negedge clk);
    outReady = 1;
    while (!outValid) @(negedge clk);
    p = outPixel;
    @(posedge clk); #1;
    outReady = 0;
  endtask

  task automatic runPair(input string req, input logic [31:0] w,
                         input logic [31:0] exp0, input logic [31:0] exp1);
    logic [31:0] p0, p1;
    pushWord(w);
    popPixel(p0);
    popPixel(p1);
    check({req, " first"}, p0, exp0);
    check({req, " second"}, p1, exp1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 reset outValid", {31'b0, outValid}, 32'd0);
    check("R9 reset inReady", {31'b0, inReady}, 32'd1);
  endtask

  task automatic testNeutral();
    // R2 black at luma 16, R3/R4/R5 near-white at luma 235, R1 order
    runPair("R2 R1 neutral", 32'h80EB8010, 32'h00000000, 32'h00FEFEFE);
    runPair("R3 R4 R5 model", 32'h40C0A050, refPix(32'h40C0A050, 0), refPix(32'h40C0A050, 1));
    runPair("R3 R4 R5 model2", 32'hB0609020, refPix(32'hB0609020, 0), refPix(32'hB0609020, 1));
  endtask

  task automatic testClamp();
    // R6/R7: y1=16 v=255 y2=235 u=255 -> R=202, G neg->0, B over->255
    runPair("R6 R7 R8 clamp", 32'hFFEBFF10, 32'h00FF00CA, refPix(32'hFFEBFF10, 1));
    // R6: chroma 0, luma 16 -> red and blue negative
    runPair("R6 low clamp", 32'h00100010, refPix(32'h00100010, 0), refPix(32'h00100010, 1));
    // R8: top byte zero with all ones input
    runPair("R8 top byte", 32'hFFFFFFFF, refPix(32'hFFFFFFFF, 0), refPix(32'hFFFFFFFF, 1));
  endtask

  task automatic testBackpressure();
    logic [31:0] w, p;
    w = 32'h6A9C3421;
    pushWord(w);
    @(negedge clk);
    inValid = 1; inData = 32'h12345678;   // should not be taken
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 hold first", outPixel, refPix(w, 0));
      check("R9 ready low first", {31'b0, inReady}, 32'd0);
    end
    inValid = 0;
    popPixel(p);
    check("R10 first after stall", p, refPix(w, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 hold second", outPixel, refPix(w, 1));
      check("R9 ready low second", {31'b0, inReady}, 32'd0);
    end
    popPixel(p);
    check("R10 second after stall", p, refPix(w, 1));
    @(negedge clk);
    check("R9 drained outValid", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testStream();
    logic [31:0] words [4];
    int idx, got, cycles;
    bit acc;
    words[0] = 32'h80EB8010; words[1] = 32'hFFEBFF10;
    words[2] = 32'h3377AA55; words[3] = 32'hC8206E90;
    idx = 0; got = 0; cycles = 0;
    while (got < 8 && cycles < 40) begin
      @(negedge clk);
      outReady = 1;
      inValid = (idx < 4);
      inData = (idx < 4) ? words[idx] : '0;
      acc = inValid && inReady;
      if (outValid) begin
        check("R11 R1 stream pixel", outPixel, refPix(words[got/2], got % 2 == 1));
        got++;
      end
      @(posedge clk); #1;
      if (acc) idx++;
      cycles++;
    end
    inValid = 0; outReady = 0;
    check("R11 stream cycles", cycles, 32'd9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    testReset();
    testNeutral();
    testClamp();
    testBackpressure();
    testStream();
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errors);
    $finish;
  end
endmodule